// File: doc/BRIEF.md
# Key-Locked Configuration Watchdog

This block is a watchdog timer whose settings sit behind a byte-wide index/data port pair. Software first writes the unlock key to the index port twice in a row. It then selects the watchdog page through a page-switch register. Only after both steps can it reach the watchdog settings: the enable bit, the count unit, the countdown value and the keyboard/mouse reload permissions. Writing the lock code to the index port ends the session and hides the registers again.

Once enabled, the countdown decrements on every seconds tick or every minutes tick, depending on the unit bit. When a nonzero count reaches zero, the block emits a one-cycle reset pulse. The count then rests at zero until it is loaded again. Keyboard and mouse interrupt events can restore the count to the last value software wrote, if each is permitted. The tick generators and the host bus decode lie outside the block.

Top module: `cfgport_watchdog`

## Requirements
- R1: After reset the configuration space is locked, a data-port read returns 0xFF, the watchdog is disabled with count 0, and `wdt_reset` is low.
- R2: The space unlocks only after two back-to-back index-port writes of 0x87. Before that, data-port writes change no watchdog register and data-port reads return 0xFF.
- R3: Any other index-port write between the two 0x87 writes returns the block to the locked state.
- R4: While unlocked, writing index 0x07 and then data 0x08 selects the watchdog page. Any other data value written to index 0x07 deselects it. Without the page, reads return 0xFF and writes are ignored.
- R5: Writing 0xAA to the index port while unlocked locks the space and deselects the page, so a later unlock must select the page again.
- R6: Register 0x30 bit 0 is the enable (1 = run). It reads back with all other bits 0.
- R7: Register 0xF5 bit 3 selects the unit: 0 decrements on `sec_tick`, 1 on `min_tick`. The other tick has no effect. It reads back with all other bits 0.
- R8: Writing register 0xF6 loads the count and the reload value at once. Reading 0xF6 returns the live count.
- R9: The count decrements by one per selected tick only while enabled. It never wraps below 0, and it holds while disabled.
- R10: In the cycle in which an enabled count steps from 1 to 0, `wdt_reset` is high for exactly one cycle. A count of 0 at enable produces no pulse.
- R11: Register 0xF7 bit 6 lets `kbd_evt` and bit 7 lets `mouse_evt` restore the count to the last value written to 0xF6. With a bit clear, its event has no effect. The register reads back with bits 5..0 at 0.
- R12: Reads of any other index on the open page return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the selected port |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Data-port read value |
| sec_tick | input | 1 | One-cycle seconds tick |
| min_tick | input | 1 | One-cycle minutes tick |
| kbd_evt | input | 1 | Keyboard interrupt event |
| mouse_evt | input | 1 | Mouse interrupt event |
| wdt_reset | output | 1 | One-cycle reset pulse on expiry |

## Verification
On every cycle, the assertions check these properties:
- the open state is reached only from the half-unlocked state;
- the lock code always relocks;
- settings do not change when the page is not reachable;
- the count holds while disabled and never wraps below zero;
- a reset pulse lasts one cycle and coincides with a zero count.

Only the bench scenarios can show the register-level behaviour:
- that the back-to-back key rule and page selection gate register access;
- the exact decrement arithmetic for each loaded value, with the pulse landing on the final tick;
- that the unit bit picks the right tick;
- that each event permission bit restores the written value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] KEY_UNLOCK = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_LOCK   = 8'hAA;
  localparam logic [BYTE_W-1:0] IDX_PAGESW = 8'h07;
  localparam logic [BYTE_W-1:0] PAGE_WDOG  = 8'h08;
  localparam logic [BYTE_W-1:0] REG_ENABLE = 8'h30;
  localparam logic [BYTE_W-1:0] REG_UNIT   = 8'hF5;
  localparam logic [BYTE_W-1:0] REG_COUNT  = 8'hF6;
  localparam logic [BYTE_W-1:0] REG_WAKE   = 8'hF7;
  localparam logic [BYTE_W-1:0] RD_IDLE    = 8'hFF;

  localparam int EN_BIT    = 0;
  localparam int UNIT_BIT  = 3;
  localparam int KBD_BIT   = 6;
  localparam int MOUSE_BIT = 7;

  typedef enum logic [1:0] {KL_LOCKED, KL_HALF, KL_OPEN} keystate_t;

  // Saturating decrement of the countdown.
  function automatic logic [BYTE_W-1:0] count_step(input logic [BYTE_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // Pick the tick that matches the selected unit.
  function automatic logic unit_tick(input logic unit_min, input logic sec, input logic min);
    return unit_min ? min : sec;
  endfunction
endpackage

// File: rtl/wdog_keylock.sv
module wdog_keylock
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              open_o,
  output logic              page_ok_o,
  output logic [BYTE_W-1:0] index_o
);
  keystate_t         st;
  logic [BYTE_W-1:0] idx;
  logic              page;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= KL_LOCKED;
      idx  <= '0;
      page <= 1'b0;
    end else begin
      if (idx_wr) begin
        case (st)
          KL_LOCKED: st <= (wdata == KEY_UNLOCK) ? KL_HALF : KL_LOCKED;
          KL_HALF:   st <= (wdata == KEY_UNLOCK) ? KL_OPEN : KL_LOCKED;
          KL_OPEN: begin
            if (wdata == KEY_LOCK) begin
              st   <= KL_LOCKED;
              page <= 1'b0;
              idx  <= '0;
            end else begin
              idx <= wdata;
            end
          end
          default: st <= KL_LOCKED;
        endcase
      end
      if (dat_wr && st == KL_OPEN && idx == IDX_PAGESW)
        page <= (wdata == PAGE_WDOG);
    end
  end

  assign open_o    = (st == KL_OPEN);
  assign page_ok_o = page;
  assign index_o   = idx;

  // R2: open is reachable only through the half-unlocked state
  a_r2_open_via_half: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KL_LOCKED) |=> (st != KL_OPEN));
  // R3: a non-key index write in the half state relocks
  a_r3_break_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KL_HALF && idx_wr && wdata != KEY_UNLOCK) |=> (st == KL_LOCKED));
  // R5: the lock code closes the session and drops the page
  a_r5_lock_code: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KL_OPEN && idx_wr && wdata == KEY_LOCK) |=> (st == KL_LOCKED && !page));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [BYTE_W-1:0] index,
  input  logic [BYTE_W-1:0] wdata,
  output logic              en_o,
  output logic              unit_o,
  output logic              kbd_o,
  output logic              mouse_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] preset_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o     <= 1'b0;
      unit_o   <= 1'b0;
      kbd_o    <= 1'b0;
      mouse_o  <= 1'b0;
      preset_o <= '0;
    end else if (wr_hit) begin
      case (index)
        REG_ENABLE: en_o <= wdata[EN_BIT];
        REG_UNIT:   unit_o <= wdata[UNIT_BIT];
        REG_COUNT:  preset_o <= wdata;
        REG_WAKE: begin
          kbd_o   <= wdata[KBD_BIT];
          mouse_o <= wdata[MOUSE_BIT];
        end
        default: ;
      endcase
    end
  end

  assign load_o = wr_hit && (index == REG_COUNT);
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              unit_min,
  input  logic              sec_tick,
  input  logic              min_tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              reload,
  input  logic [BYTE_W-1:0] preset,
  output logic [BYTE_W-1:0] cnt_o,
  output logic              fire_o
);
  logic tick_sel;
  logic step;
  logic expire;

  assign tick_sel = unit_tick(unit_min, sec_tick, min_tick);
  assign step     = en && tick_sel && (cnt_o != '0);
  assign expire   = step && !load && !reload && (cnt_o == 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      fire_o <= 1'b0;
    end else begin
      if (load)        cnt_o <= load_val;
      else if (reload) cnt_o <= preset;
      else if (step)   cnt_o <= count_step(cnt_o);
      fire_o <= expire;
    end
  end

  // R8: a load places the written byte in the count
  a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_o == $past(load_val)));
  // R9: the count holds while disabled
  a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load && !reload) |=> $stable(cnt_o));
  // R9: zero never wraps
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == '0 && !load && !reload) |=> (cnt_o == '0));
  // R10: the pulse lasts one cycle and coincides with a zero count
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
  a_r10_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (cnt_o == '0));
endmodule

// File: rtl/cfgport_watchdog.sv
module cfgport_watchdog
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              port_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              sec_tick,
  input  logic              min_tick,
  input  logic              kbd_evt,
  input  logic              mouse_evt,
  output logic              wdt_reset
);
  logic              idx_wr, dat_wr, open, page_ok, access, wr_hit;
  logic [BYTE_W-1:0] index, preset, cnt;
  logic              en, unit_min, kbd_en, mouse_en, load, reload;

  assign idx_wr = wr_en && !port_sel;
  assign dat_wr = wr_en && port_sel;

  wdog_keylock u_keylock (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr), .wdata(wdata),
    .open_o(open), .page_ok_o(page_ok), .index_o(index)
  );

  assign access = open && page_ok;
  assign wr_hit = dat_wr && access;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .index(index), .wdata(wdata),
    .en_o(en), .unit_o(unit_min), .kbd_o(kbd_en), .mouse_o(mouse_en),
    .load_o(load), .preset_o(preset)
  );

  assign reload = (kbd_evt && kbd_en) || (mouse_evt && mouse_en);

  wdog_countdown u_count (
    .clk(clk), .rst_n(rst_n), .en(en), .unit_min(unit_min),
    .sec_tick(sec_tick), .min_tick(min_tick), .load(load), .load_val(wdata),
    .reload(reload), .preset(preset), .cnt_o(cnt), .fire_o(wdt_reset)
  );

  always_comb begin
    rdata = RD_IDLE;
    if (access) begin
      case (index)
        REG_ENABLE: begin rdata = '0; rdata[EN_BIT] = en; end
        REG_UNIT:   begin rdata = '0; rdata[UNIT_BIT] = unit_min; end
        REG_COUNT:  rdata = cnt;
        REG_WAKE: begin
          rdata = '0;
          rdata[KBD_BIT]   = kbd_en;
          rdata[MOUSE_BIT] = mouse_en;
        end
        default: rdata = RD_IDLE;
      endcase
    end
  end

  // R4: settings are untouched when the page is not reachable
  a_r4_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !access) |=> $stable({en, unit_min, kbd_en, mouse_en, preset}));
  // R2: the data port reads idle while not open
  a_r2_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !open |-> (rdata == RD_IDLE));
endmodule

// File: tb/cfgport_watchdog_test.sv
module cfgport_watchdog_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, port_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sec_tick = 1'b0, min_tick = 1'b0, kbd_evt = 1'b0, mouse_evt = 1'b0;
  logic       wdt_reset;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfgport_watchdog uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel), .wdata(wdata),
    .rdata(rdata), .sec_tick(sec_tick), .min_tick(min_tick), .kbd_evt(kbd_evt),
    .mouse_evt(mouse_evt), .wdt_reset(wdt_reset)
  );

  always @(posedge clk) if (rst_n && wdt_reset) pulses++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    @(negedge clk); port_sel = sel; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input int exp);
    @(negedge clk); port_sel = 1'b1; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic setreg(input logic [7:0] i, input logic [7:0] v);
    wr(0, i); wr(1, v);
  endtask

  task automatic getreg(input string tag, input logic [7:0] i, input int exp);
    wr(0, i); rd(tag, exp);
  endtask

  task automatic open_page();
    wr(0, 8'h87); wr(0, 8'h87); setreg(8'h07, 8'h08);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 idle read", 8'hFF);
    chk("R1 no pulse", wdt_reset, 0);
    // R2: writes before unlock are ignored
    setreg(8'h07, 8'h08); setreg(8'h30, 8'h01); setreg(8'hF6, 8'h09);
    rd("R2 locked read", 8'hFF);
    wr(0, 8'h87); wr(0, 8'h87);
    getreg("R4 no page read", 8'h30, 8'hFF);
    wr(1, 8'h01);
    setreg(8'h07, 8'h08);
    getreg("R2 enable untouched", 8'h30, 8'h00);
    getreg("R2 count untouched", 8'hF6, 8'h00);
    getreg("R4 enable still off", 8'h30, 8'h00);
    // R4: a wrong page value deselects
    setreg(8'h07, 8'h05);
    getreg("R4 wrong page", 8'hF6, 8'hFF);
    setreg(8'h07, 8'h08);
    getreg("R12 unknown index", 8'h42, 8'hFF);
    // R6, R7, R11 readback masks
    setreg(8'h30, 8'hFE); getreg("R6 enable mask off", 8'h30, 8'h00);
    setreg(8'h30, 8'hFF); getreg("R6 enable mask on", 8'h30, 8'h01);
    setreg(8'hF5, 8'hF7); getreg("R7 unit mask off", 8'hF5, 8'h00);
    setreg(8'hF5, 8'hFF); getreg("R7 unit mask on", 8'hF5, 8'h08);
    setreg(8'hF7, 8'hFF); getreg("R11 wake mask", 8'hF7, 8'hC0);
    setreg(8'hF7, 8'h00); setreg(8'hF5, 8'h00); setreg(8'h30, 8'h00);
    // R8: full sweep of loaded values while disabled
    for (int v = 0; v < 256; v++) begin
      setreg(8'hF6, v[7:0]); rd("R8 load readback", v);
    end
    // R9: disabled count holds across ticks
    setreg(8'hF6, 8'd5);
    wr(0, 8'hF6);
    for (int k = 0; k < 3; k++) pulse(sec_tick);
    rd("R9 hold when off", 5);
    // R10: zero count at enable never pulses
    setreg(8'hF6, 8'd0); setreg(8'h30, 8'h01);
    p0 = pulses;
    wr(0, 8'hF6);
    for (int k = 0; k < 4; k++) pulse(sec_tick);
    rd("R9 no wrap", 0);
    chk("R10 no pulse from zero", pulses - p0, 0);
    // R9/R10 countdown sweep, seconds unit
    for (int v = 1; v <= 40; v++) begin
      setreg(8'hF6, v[7:0]);
      wr(0, 8'hF6);
      p0 = pulses;
      for (int k = 1; k < v; k++) pulse(sec_tick);
      rd("R9 countdown", 1);
      chk("R10 no early pulse", pulses - p0, 0);
      pulse(sec_tick);
      chk("R10 pulse on zero", wdt_reset, 1);
      @(negedge clk);
      chk("R10 pulse ends", wdt_reset, 0);
      rd("R9 rests at zero", 0);
      chk("R10 one pulse", pulses - p0, 1);
    end
    // R7: minutes unit ignores seconds ticks
    setreg(8'hF5, 8'h08); setreg(8'hF6, 8'd3);
    wr(0, 8'hF6);
    pulse(sec_tick); pulse(sec_tick);
    rd("R7 sec ignored in min unit", 3);
    pulse(min_tick);
    rd("R7 min tick counts", 2);
    setreg(8'hF5, 8'h00);
    wr(0, 8'hF6);
    pulse(min_tick);
    rd("R7 min ignored in sec unit", 2);
    // R11: event reload permissions
    setreg(8'hF6, 8'd20);
    wr(0, 8'hF6);
    for (int k = 0; k < 6; k++) pulse(sec_tick);
    rd("R11 before events", 14);
    pulse(kbd_evt); pulse(mouse_evt);
    rd("R11 events blocked", 14);
    setreg(8'hF7, 8'h40); wr(0, 8'hF6);
    pulse(mouse_evt);
    rd("R11 mouse blocked", 14);
    pulse(kbd_evt);
    rd("R11 kbd reload", 20);
    setreg(8'hF7, 8'h80); wr(0, 8'hF6);
    pulse(sec_tick); pulse(kbd_evt);
    rd("R11 kbd blocked", 19);
    pulse(mouse_evt);
    rd("R11 mouse reload", 20);
    // R5: lock closes and drops the page
    wr(0, 8'hAA);
    rd("R5 locked read", 8'hFF);
    wr(0, 8'h87); wr(0, 8'h87);
    getreg("R5 page dropped", 8'hF6, 8'hFF);
    wr(0, 8'hAA);
    // R3: interrupted key sequence
    wr(0, 8'h87); wr(0, 8'h55); wr(0, 8'h87);
    setreg(8'h07, 8'h08);
    getreg("R3 broken key stays locked", 8'hF6, 8'hFF);
    wr(0, 8'hAA);
    open_page();
    getreg("R3 clean key opens", 8'hF6, 20);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule